// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Controller

This block is the memory-side engine of an audio FIFO. It steps through a circular buffer in system memory, one fixed-size burst at a time. Software programs a base address and the address of the final burst in the ring. After the final burst is acknowledged, the pointer returns to the base. A burst counter raises a repeating period interrupt after a programmed number of bursts. A second source flags each wrap of the ring.

Memory traffic uses a level request with a one-cycle acknowledge. Each cycle in which both are high completes one burst at the address shown. Software reaches the block through a word-strided 32-bit register file. Writes are single-cycle strobes and reads are combinational from the address. A selectable status word exposes the live pointer, so software can compute its ring position by subtracting the base.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset, every register reads 0, `mem_req` is low and `irq` is low.
- R2: Registers sit at byte offsets 0x00 control-0, 0x04 control-1, 0x08 base, 0x0C last-burst address, 0x10 period count, 0x14 status-1 and 0x18 status-2. Control-0 has the run bit at bit 0 and the per-source interrupt enables at bits [9:8]. Control-1 has the per-source clear bits at [1:0] and the status-2 selector at [17:16]. Written fields read back unchanged, and offset 0x1C reads 0.
- R3: `mem_req` is high exactly while the run bit is set. Each acknowledged burst advances `mem_addr` by 64 bytes.
- R4: The burst completed at the last-burst address is followed by the base address.
- R5: Clearing the run bit drops `mem_req`, and the pointer holds even if `mem_ack` toggles. Setting the run bit again resumes at the held pointer.
- R6: Status-1 bit 0 (period) sets once every N completed bursts, where N is the period count, and the counter then restarts. N = 0 never sets it.
- R7: Status-1 bit 1 (wrap) sets when the burst at the last-burst address completes.
- R8: `irq` is high exactly when some status bit and its enable bit are both set.
- R9: While a clear bit is held at 1, the matching status bit reads 0 one cycle after the write and stays 0 through new events. It is not set again until software writes the clear bit back to 0 and a new event occurs.
- R10: An event that completes in the same cycle as the write releasing its clear bit is recorded.
- R11: The status-2 selector chooses what status-2 shows: 0 gives the current pointer as a byte address, 1 gives the bursts counted in the current period, and 2 and 3 give 0.
- R12: Writing the base or last-burst address while the run bit is clear reloads the pointer to the base and restarts the period count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Burst request |
| mem_addr | output | ADDR_W (32) | Byte address of the requested burst |
| mem_ack | input | 1 | Burst complete, sampled with mem_req |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the ring across the last-burst boundary several times and checks every burst address. A design that stepped past the last burst, or that treated the last-burst address as the buffer end, would fail there. It pauses with `mem_ack` still toggling, to catch a pointer that drifts while stopped. It also releases a clear in the very cycle a period completes, which a design that lets a stale clear win would lose. It reloads the pointer mid-period to expose a burst counter that survives the reload, and runs with a period count of 0 to catch a counter that fires on wrap-around.

// File: rtl/ard_pkg.sv
package ard_pkg;
   // word index of each register (byte offset / 4)
   localparam logic [2:0] RG_CTRL0  = 3'd0;
   localparam logic [2:0] RG_CTRL1  = 3'd1;
   localparam logic [2:0] RG_START  = 3'd2;
   localparam logic [2:0] RG_FINISH = 3'd3;
   localparam logic [2:0] RG_PERIOD = 3'd4;
   localparam logic [2:0] RG_STAT1  = 3'd5;
   localparam logic [2:0] RG_STAT2  = 3'd6;

   // field positions
   localparam int unsigned RUN_BIT = 0;
   localparam int unsigned EN_LSB  = 8;
   localparam int unsigned CLR_LSB = 0;
   localparam int unsigned SEL_LSB = 16;
   localparam int unsigned MAX_SRC = 8;

   // interrupt sources
   localparam int unsigned SRC_PERIOD = 0;
   localparam int unsigned SRC_WRAP   = 1;

   typedef enum logic [1:0] {
      S2_PTR  = 2'd0,
      S2_CNT  = 2'd1,
      S2_RSV2 = 2'd2,
      S2_RSV3 = 2'd3
   } s2_sel_e;
endpackage

// File: rtl/ard_addr_gen.sv
module ard_addr_gen #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BURST_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              mem_ack_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic [ADDR_W-1:0] finish_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              done_o,
   output logic              wrap_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

   logic [ADDR_W-1:0] ptr_q;
   logic              at_last;

   assign mem_req_o  = run_i;
   assign mem_addr_o = ptr_q;
   assign done_o     = run_i & mem_ack_i;
   assign at_last    = (ptr_q == finish_i);
   assign wrap_o     = done_o & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (load_i)  ptr_q <= load_val_i;
      else if (done_o)  ptr_q <= at_last ? start_i : ptr_q + STEP;
   end
endmodule

// File: rtl/ard_period_cnt.sv
module ard_period_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             evt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + 1'b1;
   assign evt_o   = done_i && (period_i != '0) && (cnt_inc >= period_i);
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (done_i)    cnt_q <= evt_o ? '0 : cnt_inc;
   end
endmodule

// File: rtl/ard_irq.sv
module ard_irq #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] sts_o,
   output logic               irq_o
);
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sts_o[k] <= 1'b0;
         else if (clr_i[k]) sts_o[k] <= 1'b0;
         else if (evt_i[k]) sts_o[k] <= 1'b1;
      end
   end

   assign irq_o = |(sts_o & en_i);
endmodule

// File: rtl/ard_regs.sv
module ard_regs
   import ard_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [4:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [ADDR_W-1:0]  ptr_i,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic [NUM_SRC-1:0] sts_i,
   output logic               run_o,
   output logic [NUM_SRC-1:0] en_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [ADDR_W-1:0]  start_o,
   output logic [ADDR_W-1:0]  finish_o,
   output logic [CNT_W-1:0]   period_o,
   output logic               load_o,
   output logic [ADDR_W-1:0]  load_val_o
);
   logic [2:0]         idx;
   logic               wr_c0, wr_c1, wr_st, wr_fi, wr_pe;
   logic [NUM_SRC-1:0] clr_q;
   s2_sel_e            sel_q;
   logic [1:0]         unused_lsb;

   assign idx        = reg_addr[4:2];
   assign unused_lsb = reg_addr[1:0];
   assign wr_c0 = reg_we && (idx == RG_CTRL0);
   assign wr_c1 = reg_we && (idx == RG_CTRL1);
   assign wr_st = reg_we && (idx == RG_START);
   assign wr_fi = reg_we && (idx == RG_FINISH);
   assign wr_pe = reg_we && (idx == RG_PERIOD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o    <= 1'b0;
         en_o     <= '0;
         clr_q    <= '0;
         sel_q    <= S2_PTR;
         start_o  <= '0;
         finish_o <= '0;
         period_o <= '0;
      end else begin
         if (wr_c0) begin
            run_o <= reg_wdata[RUN_BIT];
            en_o  <= reg_wdata[EN_LSB +: NUM_SRC];
         end
         if (wr_c1) begin
            clr_q <= reg_wdata[CLR_LSB +: NUM_SRC];
            sel_q <= s2_sel_e'(reg_wdata[SEL_LSB +: 2]);
         end
         if (wr_st) start_o  <= reg_wdata[ADDR_W-1:0];
         if (wr_fi) finish_o <= reg_wdata[ADDR_W-1:0];
         if (wr_pe) period_o <= reg_wdata[CNT_W-1:0];
      end
   end

   // a clear being released this cycle no longer blocks a same-cycle event
   assign clr_o      = wr_c1 ? (clr_q & reg_wdata[CLR_LSB +: NUM_SRC]) : clr_q;
   assign load_o     = (wr_st || wr_fi) && !run_o;
   assign load_val_o = wr_st ? reg_wdata[ADDR_W-1:0] : start_o;

   always_comb begin
      reg_rdata = '0;
      case (idx)
         RG_CTRL0: begin
            reg_rdata[RUN_BIT]             = run_o;
            reg_rdata[EN_LSB +: NUM_SRC]   = en_o;
         end
         RG_CTRL1: begin
            reg_rdata[CLR_LSB +: NUM_SRC]  = clr_q;
            reg_rdata[SEL_LSB +: 2]        = sel_q;
         end
         RG_START:  reg_rdata = 32'(start_o);
         RG_FINISH: reg_rdata = 32'(finish_o);
         RG_PERIOD: reg_rdata = 32'(period_o);
         RG_STAT1:  reg_rdata = 32'(sts_i);
         RG_STAT2: begin
            case (sel_q)
               S2_PTR:  reg_rdata = 32'(ptr_i);
               S2_CNT:  reg_rdata = 32'(cnt_i);
               default: reg_rdata = '0;
            endcase
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
   import ard_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BURST_BYTES = 64,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned NUM_SRC     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [4:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic              irq
);
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W must lie in 8..32");
   end
   if (BURST_BYTES < 8 || (BURST_BYTES & (BURST_BYTES - 1)) != 0) begin : g_bad_burst
      $error("BURST_BYTES must be a power of two of at least 8");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..32");
   end
   if (NUM_SRC < 2 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must lie in 2..8");
   end

   logic               run, load, done, wrap, per_evt;
   logic [NUM_SRC-1:0] en, clr_eff, sts, evt;
   logic [ADDR_W-1:0]  start, finish, load_val;
   logic [CNT_W-1:0]   period, cnt;

   always_comb begin
      evt             = '0;
      evt[SRC_PERIOD] = per_evt;
      evt[SRC_WRAP]   = wrap;
   end

   ard_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr_i(mem_addr),
      .cnt_i(cnt), .sts_i(sts), .run_o(run), .en_o(en), .clr_o(clr_eff),
      .start_o(start), .finish_o(finish), .period_o(period),
      .load_o(load), .load_val_o(load_val)
   );

   ard_addr_gen #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .run_i(run), .mem_ack_i(mem_ack),
      .start_i(start), .finish_i(finish), .load_i(load),
      .load_val_i(load_val), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
      .done_o(done), .wrap_o(wrap)
   );

   ard_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .done_i(done), .restart_i(load),
      .period_i(period), .cnt_o(cnt), .evt_o(per_evt)
   );

   ard_irq #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .clr_i(clr_eff),
      .sts_o(sts), .irq_o(irq)
   );
endmodule

// File: rtl/ard_chk.sv
module ard_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BURST_BYTES = 64,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned NUM_SRC     = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               load,
   input logic               reg_we,
   input logic               mem_req,
   input logic               mem_ack,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic [ADDR_W-1:0]  start,
   input logic [ADDR_W-1:0]  finish,
   input logic [CNT_W-1:0]   period,
   input logic [NUM_SRC-1:0] en,
   input logic [NUM_SRC-1:0] clr_eff,
   input logic [NUM_SRC-1:0] sts,
   input logic               irq
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

   // R3
   run_gates_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mem_req);

   // R3
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_addr != finish) |=> (mem_addr == $past(mem_addr) + STEP));

   // R4
   ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_addr == finish && !reg_we) |=> (mem_addr == start));

   // R5
   paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_req && !load) |=> $stable(mem_addr));

   // R6
   zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0) |=> !$rose(sts[0]));

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts & en) == '0) |-> !irq);

   // R9
   clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_eff != '0) |=> ((sts & $past(clr_eff)) == '0));
endmodule

bind audio_ring_dma ard_chk #(
   .ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .load(load), .reg_we(reg_we),
   .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .start(start),
   .finish(finish), .period(period), .en(en), .clr_eff(clr_eff), .sts(sts),
   .irq(irq)
);

// File: tb/audio_ring_dma_tb.sv
module audio_ring_dma_tb;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned BURST  = 64;

   localparam logic [2:0] A_C0 = 3'd0, A_C1 = 3'd1, A_ST = 3'd2, A_FI = 3'd3,
                          A_PE = 3'd4, A_S1 = 3'd5, A_S2 = 3'd6, A_NONE = 3'd7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [4:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_ack = 1'b0;
   logic              irq;

   int unsigned n_run = 0;
   int unsigned n_fail = 0;
   bit          done_flag = 1'b0;
   logic [31:0] exp_ptr, s_m, f_m;

   always #10 clk = ~clk;

   audio_ring_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = {idx, 2'b00}; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] d);
      reg_addr = {idx, 2'b00};
      #1 d = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_all(input logic [31:0] sel);
      wr(A_C1, sel | 32'h3);
      idle(1);
      wr(A_C1, sel);
   endtask

   task automatic set_ring(input logic [31:0] s, input logic [31:0] f);
      wr(A_ST, s); wr(A_FI, f);
      s_m = s; f_m = f; exp_ptr = s;
   endtask

   task automatic run_bursts(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mem_ack = 1'b1;
         check("R3 req while running", 32'(mem_req), 32'd1);
         check("R3/R4 burst address", mem_addr, exp_ptr);
         exp_ptr = (exp_ptr == f_m) ? s_m : exp_ptr + BURST;
      end
      @(negedge clk);
      mem_ack = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R1 mem_req", 32'(mem_req), 32'd0);
      check("R1 irq", 32'(irq), 32'd0);
      for (int i = 0; i < 7; i++) begin
         rd(3'(i), d);
         check("R1 register reset value", d, 32'd0);
      end
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(A_C0, 32'h0000_0300); rd(A_C0, d); check("R2 control-0 readback", d, 32'h300);
      wr(A_C0, 32'h0);
      wr(A_C1, 32'h0002_0000); rd(A_C1, d); check("R2 control-1 readback", d, 32'h2_0000);
      wr(A_C1, 32'h0);
      set_ring(32'h1000, 32'h10C0);
      wr(A_PE, 32'd3);
      rd(A_ST, d); check("R2 base readback", d, 32'h1000);
      rd(A_FI, d); check("R2 last-burst readback", d, 32'h10C0);
      rd(A_PE, d); check("R2 period readback", d, 32'd3);
      rd(A_NONE, d); check("R2 unmapped offset", d, 32'd0);
   endtask

   task automatic t_walk_wrap;
      logic [31:0] d;
      rd(A_S2, d); check("R12 pointer reloaded to base", d, 32'h1000);
      wr(A_C0, 32'h1);
      run_bursts(6);
      wr(A_C0, 32'h0);
      rd(A_S1, d);
      check("R7 wrap status set", d & 32'h2, 32'h2);
      check("R6 period status set", d & 32'h1, 32'h1);
   endtask

   task automatic t_pause;
      logic [31:0] d;
      check("R5 req low when stopped", 32'(mem_req), 32'd0);
      @(negedge clk); mem_ack = 1'b1;
      idle(3);
      mem_ack = 1'b0;
      rd(A_S2, d); check("R5 pointer held while stopped", d, exp_ptr);
      check("R5 expected held pointer", exp_ptr, 32'h1080);
      wr(A_C0, 32'h1);
      run_bursts(1);
      wr(A_C0, 32'h0);
   endtask

   task automatic t_period;
      logic [31:0] d;
      set_ring(32'h2000, 32'h20C0);
      wr(A_PE, 32'd3);
      clear_all(32'h0);
      wr(A_C0, 32'h100);
      check("R8 irq low with no status", 32'(irq), 32'd0);
      wr(A_C0, 32'h101);
      run_bursts(2);
      rd(A_S1, d); check("R6 not set before N bursts", d & 32'h1, 32'h0);
      run_bursts(1);
      rd(A_S1, d); check("R6 set after N bursts", d & 32'h1, 32'h1);
      check("R8 irq raised", 32'(irq), 32'd1);
      wr(A_C1, 32'h1);
      idle(1);
      rd(A_S1, d); check("R9 status forced clear", d & 32'h1, 32'h0);
      check("R9 irq drops after clear", 32'(irq), 32'd0);
      run_bursts(3);
      rd(A_S1, d); check("R9 event blocked while clear held", d & 32'h1, 32'h0);
      wr(A_C1, 32'h0);
      rd(A_S1, d); check("R9 release alone sets nothing", d & 32'h1, 32'h0);
      run_bursts(3);
      rd(A_S1, d); check("R6 period repeats", d & 32'h1, 32'h1);
   endtask

   task automatic t_gating;
      wr(A_C0, 32'h001);
      check("R8 status without enable keeps irq low", 32'(irq), 32'd0);
      wr(A_C0, 32'h201);
      check("R8 wrap source enabled raises irq", 32'(irq), 32'd1);
      wr(A_C0, 32'h000);
      check("R8 irq low after disabling enables", 32'(irq), 32'd0);
   endtask

   task automatic t_release_event;
      logic [31:0] d;
      wr(A_C1, 32'h3);
      idle(1);
      wr(A_PE, 32'd1);
      wr(A_C0, 32'h1);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = {A_C1, 2'b00}; reg_wdata = 32'h0;
      mem_ack = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; mem_ack = 1'b0;
      exp_ptr = (exp_ptr == f_m) ? s_m : exp_ptr + BURST;
      wr(A_C0, 32'h0);
      rd(A_S1, d); check("R10 event in release cycle kept", d & 32'h1, 32'h1);
   endtask

   task automatic t_select;
      logic [31:0] d;
      clear_all(32'h0);
      set_ring(32'h3000, 32'h30C0);
      wr(A_PE, 32'd4);
      wr(A_C0, 32'h1);
      run_bursts(2);
      wr(A_C0, 32'h0);
      wr(A_C1, 32'h1_0000); rd(A_S2, d); check("R11 selector 1 burst count", d, 32'd2);
      wr(A_C1, 32'h2_0000); rd(A_S2, d); check("R11 selector 2 reads zero", d, 32'd0);
      wr(A_C1, 32'h3_0000); rd(A_S2, d); check("R11 selector 3 reads zero", d, 32'd0);
      wr(A_C1, 32'h0);      rd(A_S2, d); check("R11 selector 0 pointer", d, 32'h3080);
   endtask

   task automatic t_reload;
      logic [31:0] d;
      wr(A_PE, 32'd2);
      wr(A_C0, 32'h1);
      run_bursts(2);
      wr(A_C0, 32'h0);
      clear_all(32'h0);
      wr(A_FI, 32'h30C0);
      exp_ptr = s_m;
      rd(A_S2, d); check("R12 last-burst write reloads pointer", d, 32'h3000);
      wr(A_C0, 32'h1);
      run_bursts(1);
      rd(A_S1, d); check("R12 period count restarted", d & 32'h1, 32'h0);
      run_bursts(1);
      rd(A_S1, d); check("R12 period after restart", d & 32'h1, 32'h1);
      wr(A_C0, 32'h0);
   endtask

   task automatic t_zero_period;
      logic [31:0] d;
      clear_all(32'h0);
      wr(A_PE, 32'd0);
      wr(A_C0, 32'h1);
      run_bursts(5);
      wr(A_C0, 32'h0);
      rd(A_S1, d); check("R6 period zero never fires", d & 32'h1, 32'h0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_regs();
      t_walk_wrap();
      t_pause();
      t_period();
      t_gating();
      t_release_event();
      t_select();
      t_reload();
      t_zero_period();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=expired expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule